// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the digital phase patterns for a two-phase full-frame CCD. When a start pulse is accepted it latches its timing settings and runs one frame. The frame begins with an integration interval, during which both vertical phases stay low. It then reads the sensor out line by line. Each line has three steps:

- a three-step accumulation-mode vertical transfer;
- a settling wait for the horizontal register;
- a train of pixel periods in which the complementary horizontal phases move charge packets to the output node.

A reset clock pulses once in every pixel period and never stops, including while idle.

The final horizontal gate is split in two. One half follows the second horizontal phase, while the other half is parked low, and this steers the packets to one of two output amplifiers. The choice is frozen for the whole frame. For an external converter the block also gives a region tag for each pixel count (none, dark/dummy, image) and two sample strobes for correlated double sampling. All durations are counts of the system clock, so the same block serves any pixel rate the system clock can resolve.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: After reset the outputs have the following idle values: `busy_o`=0, `v1_o`=`v2_o`=0, `h1_o`=1, `h2_o`=`h21_o`=`h22_o`=0, `region_o`=2'b00, both strobes low.
- R2: A start pulse seen while idle latches every timing input and the amplifier select, and `busy_o` rises at that edge. Input changes and start pulses during a frame have no effect on that frame.
- R3: Integration lasts max(`int_len_i`,1) cycles, with both vertical phases low.
- R4: Each line transfer has three steps of max(`vpw_i`,1) cycles each. In the first, V1 is high and V2 is low; in the second, V1 is low and V2 is high; in the third, V1 is high and V2 is low. Both phases are low afterwards.
- R5: After the transfer, a settling wait of max(`hset_i`,1) cycles is followed by PIX_PER_LINE+1 pixel periods. A frame is LINES such lines, and `busy_o` falls exactly integration + LINES × line time cycles after it rose.
- R6: With pixel period P = max(`pix_per_i`,2), H2 is high in the last P−P/2 cycles of each period of pixel counts 1..PIX_PER_LINE, and H1 is always its complement. This gives PIX_PER_LINE H2 falling edges per line. During the extra final period H2 stays low.
- R7: `region_o` is 2'b10 (image) for counts LEAD_DARK+1 to PIX_PER_LINE−TRAIL_DARK. It is 2'b01 (dark/dummy) for the other counts from 1 to PIX_PER_LINE, and 2'b00 otherwise.
- R8: `r_o` is high for the first `rst_w_i` cycles of every pixel period. The phase counter runs freely, including while idle, and restarts at the first pixel of each line.
- R9: `ref_smp_o` pulses at phase `rst_w_i`+`smp_off_i` and `dat_smp_o` pulses at phase P−1 (the cycle before H2 falls). Each fires only while `region_o` is nonzero.
- R10: With select 0, H21 follows H2 and H22 is low. With select 1 the roles swap. The select is sampled only when a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start request |
| int_len_i | input | INT_W | Integration length in cycles |
| vpw_i | input | CNT_W | Vertical step width in cycles |
| hset_i | input | CNT_W | Horizontal settling wait in cycles |
| pix_per_i | input | CNT_W | Pixel period in cycles |
| rst_w_i | input | CNT_W | Reset clock pulse width in cycles |
| smp_off_i | input | CNT_W | Reference sample offset after reset pulse |
| amp_sel_i | input | 1 | Output amplifier select |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| h21_o | output | 1 | Split last gate toward amplifier 0 |
| h22_o | output | 1 | Split last gate toward amplifier 1 |
| r_o | output | 1 | Reset clock |
| region_o | output | 2 | Pixel region tag |
| ref_smp_o | output | 1 | Reference-level sample strobe |
| dat_smp_o | output | 1 | Data-level sample strobe |
| busy_o | output | 1 | Frame in progress |

## Verification
All outputs are decoded from registers, so each result is due in the first cycle after the clock edge that caused it. `busy_o` and the first integration cycle appear one edge after the accepted start. A stage change appears one edge after its down-counter reaches zero. The phase restart at the first pixel of a line comes from the same edge that leaves the settling wait. The bench keeps a time-indexed model: it counts cycles since the start edge and derives every expected output arithmetically from the latched settings. It compares the model with all outputs at every falling edge, where the registered values are settled. It also measures busy length and H2 falling-edge counts per frame from the ports.

// File: rtl/ccd_seq_pkg.sv
// Shared types for the CCD clock sequencer.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package ccd_seq_pkg;

    // Frame stages, in execution order after idle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTEG,
        ST_VA,
        ST_VB,
        ST_VC,
        ST_SETUP,
        ST_PIX
    } stage_t;

    // Pixel region tag encoding seen at the top-level port.
    typedef enum logic [1:0] {
        RG_NONE  = 2'b00,
        RG_DARK  = 2'b01,
        RG_IMAGE = 2'b10
    } region_t;

endpackage

// File: rtl/ccd_frame_fsm.sv
// Frame stage controller: integration, three-step vertical transfer,
// settling wait and pixel section for each line, repeated LINES times.
// Assumes INT_W >= CNT_W. A zero duration behaves as one cycle.
// The pixel section ends when the pixel engine reports its last cycle.
module ccd_frame_fsm
    import ccd_seq_pkg::*;
#(
    parameter int INT_W = 24,
    parameter int CNT_W = 16,
    parameter int LINES = 520
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [INT_W-1:0] int_len_i,
    input  logic [CNT_W-1:0] vpw_i,
    input  logic [CNT_W-1:0] hset_i,
    input  logic             pix_done_i,
    output stage_t           stage_o,
    output logic             accept_o,
    output logic             pix_start_o,
    output logic             busy_o
);

    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    stage_t             stage_q;
    logic [INT_W-1:0]   cnt_q;
    logic [LINE_W-1:0]  line_q;
    logic [CNT_W-1:0]   vpw_q;
    logic [CNT_W-1:0]   hset_q;
    logic               cnt_zero;

    // Converts a duration into a down-counter preload (zero acts as one).
    function automatic logic [INT_W-1:0] span(input logic [INT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    assign cnt_zero    = (cnt_q == '0);
    assign accept_o    = start_i && (stage_q == ST_IDLE);
    assign pix_start_o = (stage_q == ST_SETUP) && cnt_zero;
    assign busy_o      = (stage_q != ST_IDLE);
    assign stage_o     = stage_q;

    // Latches per-frame durations when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpw_q  <= '0;
            hset_q <= '0;
        end else if (accept_o) begin
            vpw_q  <= vpw_i;
            hset_q <= hset_i;
        end
    end

    // Advances through the frame stages using one shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            cnt_q   <= '0;
            line_q  <= '0;
        end else begin
            unique case (stage_q)
                ST_IDLE: begin
                    if (start_i) begin
                        stage_q <= ST_INTEG;
                        cnt_q   <= span(int_len_i);
                        line_q  <= '0;
                    end
                end
                ST_INTEG: begin
                    if (cnt_zero) begin
                        stage_q <= ST_VA;
                        cnt_q   <= span(INT_W'(vpw_q));
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_VA: begin
                    if (cnt_zero) begin
                        stage_q <= ST_VB;
                        cnt_q   <= span(INT_W'(vpw_q));
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_VB: begin
                    if (cnt_zero) begin
                        stage_q <= ST_VC;
                        cnt_q   <= span(INT_W'(vpw_q));
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_VC: begin
                    if (cnt_zero) begin
                        stage_q <= ST_SETUP;
                        cnt_q   <= span(INT_W'(hset_q));
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cnt_zero) begin
                        stage_q <= ST_PIX;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_PIX: begin
                    if (pix_done_i) begin
                        if (line_q == LAST_LINE) begin
                            stage_q <= ST_IDLE;
                        end else begin
                            stage_q <= ST_VA;
                            cnt_q   <= span(INT_W'(vpw_q));
                            line_q  <= line_q + 1'b1;
                        end
                    end
                end
                default: stage_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ccd_pixel_engine.sv
// Pixel-rate timing: free-running phase counter, pixel count within a
// line, horizontal phase 2, reset clock, region tag and sample strobes.
// Assumes rst_w + smp_off < period so that both strobes fall inside a period.
// The period is clamped to at least two cycles when it is latched.
module ccd_pixel_engine
    import ccd_seq_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PIX_PER_LINE = 530,
    parameter int LEAD_DARK    = 8,
    parameter int TRAIL_DARK   = 10,
    parameter int DEF_PIX      = 10,
    parameter int DEF_RST      = 2,
    parameter int DEF_OFF      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] pix_per_i,
    input  logic [CNT_W-1:0] rst_w_i,
    input  logic [CNT_W-1:0] smp_off_i,
    input  logic             pix_start_i,
    output logic             h2_o,
    output logic             r_o,
    output region_t          region_o,
    output logic             ref_smp_o,
    output logic             dat_smp_o,
    output logic             pix_done_o
);

    localparam int LAST_PC   = PIX_PER_LINE + 1;
    localparam int PC_W      = $clog2(LAST_PC + 1);
    localparam int FIRST_IMG = LEAD_DARK + 1;
    localparam int LAST_IMG  = PIX_PER_LINE - TRAIL_DARK;

    logic [CNT_W-1:0] per_q, rw_q, off_q, ph_q, half;
    logic [CNT_W:0]   ref_at;
    logic [PC_W-1:0]  pc_q;
    logic             wrap, shifting;

    assign wrap     = (ph_q >= per_q - 1'b1);
    assign half     = per_q >> 1;
    assign ref_at   = {1'b0, rw_q} + {1'b0, off_q};
    assign shifting = (pc_q != '0) && (pc_q <= PC_W'(PIX_PER_LINE));

    // Latches the pixel-rate settings for the coming frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= CNT_W'(DEF_PIX);
            rw_q  <= CNT_W'(DEF_RST);
            off_q <= CNT_W'(DEF_OFF);
        end else if (load_i) begin
            per_q <= (pix_per_i < CNT_W'(2)) ? CNT_W'(2) : pix_per_i;
            rw_q  <= rst_w_i;
            off_q <= smp_off_i;
        end
    end

    // Phase within the pixel period; runs always, restarts at a line's first pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (pix_start_i || wrap) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Pixel count within the line: 0 outside the pixel section, then 1..LAST_PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pix_start_i) begin
            pc_q <= PC_W'(1);
        end else if ((pc_q != '0) && wrap) begin
            pc_q <= (pc_q == PC_W'(LAST_PC)) ? '0 : pc_q + 1'b1;
        end
    end

    // Region decode of the current pixel count.
    always_comb begin
        if (!shifting) begin
            region_o = RG_NONE;
        end else if ((pc_q >= PC_W'(FIRST_IMG)) && (pc_q <= PC_W'(LAST_IMG))) begin
            region_o = RG_IMAGE;
        end else begin
            region_o = RG_DARK;
        end
    end

    assign h2_o       = shifting && (ph_q >= half);
    assign r_o        = (ph_q < rw_q);
    assign ref_smp_o  = (region_o != RG_NONE) && ({1'b0, ph_q} == ref_at);
    assign dat_smp_o  = (region_o != RG_NONE) && wrap;
    assign pix_done_o = (pc_q == PC_W'(LAST_PC)) && wrap;

endmodule

// File: rtl/ccd_gate_steer.sv
// Split last-gate steering: routes horizontal phase 2 onto the gate of the
// selected output amplifier and parks the other gate low.
// The select is captured only on frame acceptance.
module ccd_gate_steer #(
    parameter int NUM_AMPS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                sel_i,
    input  logic                h2_i,
    output logic [NUM_AMPS-1:0] gate_o,
    output logic                sel_q_o
);

    logic sel_q;

    // Captures the amplifier select at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load_i) begin
            sel_q <= sel_i;
        end
    end

    for (genvar g = 0; g < NUM_AMPS; g++) begin : g_gate
        assign gate_o[g] = h2_i && (sel_q == 1'(g));
    end

    assign sel_q_o = sel_q;

endmodule

// File: rtl/ccd_clock_sequencer.sv
// Top level of the CCD readout clock sequencer. Ties the frame controller,
// pixel engine and gate steering together and decodes the vertical phases.
// All outputs are decoded from registered state; no input reaches an output
// combinationally except through a clock edge.
module ccd_clock_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int INT_W        = 24,
    parameter int CNT_W        = 16,
    parameter int LINES        = 520,
    parameter int PIX_PER_LINE = 530,
    parameter int LEAD_DARK    = 8,
    parameter int TRAIL_DARK   = 10,
    parameter int DEF_PIX      = 10,
    parameter int DEF_RST      = 2,
    parameter int DEF_OFF      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [INT_W-1:0] int_len_i,
    input  logic [CNT_W-1:0] vpw_i,
    input  logic [CNT_W-1:0] hset_i,
    input  logic [CNT_W-1:0] pix_per_i,
    input  logic [CNT_W-1:0] rst_w_i,
    input  logic [CNT_W-1:0] smp_off_i,
    input  logic             amp_sel_i,
    output logic             v1_o,
    output logic             v2_o,
    output logic             h1_o,
    output logic             h2_o,
    output logic             h21_o,
    output logic             h22_o,
    output logic             r_o,
    output logic [1:0]       region_o,
    output logic             ref_smp_o,
    output logic             dat_smp_o,
    output logic             busy_o
);

    stage_t     stage;
    region_t    region;
    logic       accept, pix_start, pix_done, h2_raw, amp_q;
    logic [1:0] gates;

    ccd_frame_fsm #(
        .INT_W (INT_W),
        .CNT_W (CNT_W),
        .LINES (LINES)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .int_len_i   (int_len_i),
        .vpw_i       (vpw_i),
        .hset_i      (hset_i),
        .pix_done_i  (pix_done),
        .stage_o     (stage),
        .accept_o    (accept),
        .pix_start_o (pix_start),
        .busy_o      (busy_o)
    );

    ccd_pixel_engine #(
        .CNT_W        (CNT_W),
        .PIX_PER_LINE (PIX_PER_LINE),
        .LEAD_DARK    (LEAD_DARK),
        .TRAIL_DARK   (TRAIL_DARK),
        .DEF_PIX      (DEF_PIX),
        .DEF_RST      (DEF_RST),
        .DEF_OFF      (DEF_OFF)
    ) pix_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .pix_per_i   (pix_per_i),
        .rst_w_i     (rst_w_i),
        .smp_off_i   (smp_off_i),
        .pix_start_i (pix_start),
        .h2_o        (h2_raw),
        .r_o         (r_o),
        .region_o    (region),
        .ref_smp_o   (ref_smp_o),
        .dat_smp_o   (dat_smp_o),
        .pix_done_o  (pix_done)
    );

    ccd_gate_steer #(
        .NUM_AMPS (2)
    ) steer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .sel_i   (amp_sel_i),
        .h2_i    (h2_raw),
        .gate_o  (gates),
        .sel_q_o (amp_q)
    );

    // Accumulation-mode vertical phases decoded from the stage.
    assign v1_o     = (stage == ST_VA) || (stage == ST_VC);
    assign v2_o     = (stage == ST_VB);
    assign h2_o     = h2_raw;
    assign h1_o     = !h2_raw;
    assign h21_o    = gates[0];
    assign h22_o    = gates[1];
    assign region_o = region;

endmodule

// File: rtl/ccd_seq_checker.sv
// Protocol checker for the CCD clock sequencer, attached by bind.
// Observes the top-level ports plus the latched amplifier select.
module ccd_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       v1,
    input logic       v2,
    input logic       h2,
    input logic       h21,
    input logic       h22,
    input logic [1:0] region,
    input logic       ref_smp,
    input logic       dat_smp,
    input logic       busy,
    input logic       amp_q
);

    assert_v_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1 && v2));

    assert_v2_follows_v1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v2) |-> $past(v1));

    assert_v2_hands_to_v1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2) |-> v1);

    assert_idle_vertical_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!v1 && !v2));

    assert_h2_falls_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h2) |-> $past(busy));

    assert_gates_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({h21, h22}));

    assert_select_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(amp_q));

    assert_region_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (region != 2'b00) |-> busy);

    assert_strobe_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_smp || dat_smp) |-> (region != 2'b00));

endmodule

bind ccd_clock_sequencer ccd_seq_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .v1      (v1_o),
    .v2      (v2_o),
    .h2      (h2_o),
    .h21     (h21_o),
    .h22     (h22_o),
    .region  (region_o),
    .ref_smp (ref_smp_o),
    .dat_smp (dat_smp_o),
    .busy    (busy_o),
    .amp_q   (amp_q)
);

// File: tb/ccd_clock_sequencer_tb_top.sv
// Self-checking bench: a time-indexed behavioural model derives every
// expected output from the cycle count since the start edge and the
// latched settings, compared with the DUT at each falling edge.
module ccd_clock_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int INT_W      = 16;
    localparam int CNT_W      = 8;
    localparam int LINES      = 4;
    localparam int PIX        = 24;
    localparam int LEAD       = 3;
    localparam int TRAIL      = 4;
    localparam int DEF_PIX    = 6;
    localparam int DEF_RST    = 2;
    localparam int DEF_OFF    = 1;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [INT_W-1:0] int_len_i = '0;
    logic [CNT_W-1:0] vpw_i = '0, hset_i = '0, pix_per_i = '0, rst_w_i = '0, smp_off_i = '0;
    logic             amp_sel_i = 1'b0;
    logic             v1_o, v2_o, h1_o, h2_o, h21_o, h22_o, r_o, ref_smp_o, dat_smp_o, busy_o;
    logic [1:0]       region_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_clock_sequencer #(
        .INT_W (INT_W), .CNT_W (CNT_W), .LINES (LINES), .PIX_PER_LINE (PIX),
        .LEAD_DARK (LEAD), .TRAIL_DARK (TRAIL),
        .DEF_PIX (DEF_PIX), .DEF_RST (DEF_RST), .DEF_OFF (DEF_OFF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .int_len_i (int_len_i),
        .vpw_i (vpw_i), .hset_i (hset_i), .pix_per_i (pix_per_i), .rst_w_i (rst_w_i),
        .smp_off_i (smp_off_i), .amp_sel_i (amp_sel_i),
        .v1_o (v1_o), .v2_o (v2_o), .h1_o (h1_o), .h2_o (h2_o), .h21_o (h21_o),
        .h22_o (h22_o), .r_o (r_o), .region_o (region_o), .ref_smp_o (ref_smp_o),
        .dat_smp_o (dat_smp_o), .busy_o (busy_o)
    );

    // Records one comparison and reports a mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_busy = 0;
    int m_t = 0, m_I = 1, m_V = 1, m_HS = 1, m_P = DEF_PIX, m_RW = DEF_RST, m_OFF = DEF_OFF;
    int m_amp = 0, m_ph = 0, m_LT = 1;

    function automatic int atleast(input int n, input int lo);
        return (n < lo) ? lo : n;
    endfunction

    function automatic int frame_len();
        return m_I + LINES * m_LT;
    endfunction

    // Offset into the pixel section of the current line, or -1 outside it.
    function automatic int pix_w(input int t);
        int u;
        if (t < m_I) return -1;
        u = (t - m_I) % m_LT;
        if (u < 3 * m_V + m_HS) return -1;
        return u - 3 * m_V - m_HS;
    endfunction

    // Advances the model at each rising edge.
    always @(posedge clk) begin
        int ph_n;
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_P = DEF_PIX; m_RW = DEF_RST; m_OFF = DEF_OFF;
            m_amp = 0; m_ph = 0;
        end else begin
            ph_n = (m_ph >= m_P - 1) ? 0 : m_ph + 1;
            if (!m_busy && start_i) begin
                m_I   = atleast(int'(int_len_i), 1);
                m_V   = atleast(int'(vpw_i), 1);
                m_HS  = atleast(int'(hset_i), 1);
                m_P   = atleast(int'(pix_per_i), 2);
                m_RW  = int'(rst_w_i);
                m_OFF = int'(smp_off_i);
                m_amp = int'(amp_sel_i);
                m_LT  = 3 * m_V + m_HS + (PIX + 1) * m_P;
                m_busy = 1; m_t = 0;
            end else if (m_busy) begin
                if (m_t == frame_len() - 1) m_busy = 0;
                else m_t++;
            end
            if (m_busy && pix_w(m_t) == 0) ph_n = 0;
            m_ph = ph_n;
        end
    end

    // Compares every output with the model at each falling edge.
    always @(negedge clk) begin
        int u, w, pc, e_v1, e_v2, e_h2, e_reg, e_ref, e_dat;
        if (rst_n && !done) begin
            e_v1 = 0; e_v2 = 0; e_h2 = 0; e_reg = 0;
            if (m_busy && m_t >= m_I) begin
                u = (m_t - m_I) % m_LT;
                e_v1 = ((u < m_V) || (u >= 2 * m_V && u < 3 * m_V)) ? 1 : 0;
                e_v2 = (u >= m_V && u < 2 * m_V) ? 1 : 0;
                w = pix_w(m_t);
                if (w >= 0) begin
                    pc = w / m_P + 1;
                    if (pc <= PIX) begin
                        e_h2  = ((w % m_P) >= m_P / 2) ? 1 : 0;
                        e_reg = (pc >= LEAD + 1 && pc <= PIX - TRAIL) ? 2 : 1;
                    end
                end
            end
            e_ref = (e_reg != 0 && m_ph == m_RW + m_OFF) ? 1 : 0;
            e_dat = (e_reg != 0 && m_ph == m_P - 1) ? 1 : 0;
            chk("R5", "busy_o", int'(busy_o), int'(m_busy));
            chk("R3", "v1_o", int'(v1_o), e_v1);
            chk("R4", "v2_o", int'(v2_o), e_v2);
            chk("R6", "h2_o", int'(h2_o), e_h2);
            chk("R6", "h1_o", int'(h1_o), 1 - e_h2);
            chk("R10", "h21_o", int'(h21_o), (m_amp == 0) ? e_h2 : 0);
            chk("R10", "h22_o", int'(h22_o), (m_amp == 1) ? e_h2 : 0);
            chk("R8", "r_o", int'(r_o), (m_ph < m_RW) ? 1 : 0);
            chk("R7", "region_o", int'(region_o), e_reg);
            chk("R9", "ref_smp_o", int'(ref_smp_o), e_ref);
            chk("R9", "dat_smp_o", int'(dat_smp_o), e_dat);
        end
    end

    // Port-level measurements: busy length and H2 falling edges per frame.
    int busy_cycles = 0;
    int h2_falls = 0;
    logic h2_prev = 1'b0;
    always @(negedge clk) begin
        if (busy_o) busy_cycles++;
        if (h2_prev && !h2_o) h2_falls++;
        h2_prev = h2_o;
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Runs one frame with the given settings; optionally disturbs inputs mid-frame.
    task automatic run_frame(input int il, input int v, input int hs, input int p,
                             input int rw, input int off, input bit amp, input bit disturb);
        int flen;
        @(negedge clk);
        int_len_i = INT_W'(il); vpw_i = CNT_W'(v); hset_i = CNT_W'(hs);
        pix_per_i = CNT_W'(p); rst_w_i = CNT_W'(rw); smp_off_i = CNT_W'(off);
        amp_sel_i = amp;
        busy_cycles = 0; h2_falls = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "busy after start", int'(busy_o), 1);
        flen = atleast(il, 1) + LINES * (3 * atleast(v, 1) + atleast(hs, 1) + (PIX + 1) * atleast(p, 2));
        if (disturb) begin
            repeat (20) @(negedge clk);
            // R2: these changes and the extra start must not affect the frame.
            int_len_i = 3; vpw_i = 7; hset_i = 9; pix_per_i = 11; rst_w_i = 5;
            smp_off_i = 4; amp_sel_i = ~amp; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        chk("R5", "frame length", busy_cycles, flen);
        chk("R6", "H2 falling edges", h2_falls, LINES * PIX);
        repeat (25) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: idle values while and just after reset.
        chk("R1", "busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy idle", int'(busy_o), 0);
        chk("R1", "v1/v2 idle", int'(v1_o) + int'(v2_o), 0);
        chk("R1", "h1 idle", int'(h1_o), 1);
        chk("R1", "h2/h21/h22 idle", int'(h2_o) + int'(h21_o) + int'(h22_o), 0);
        chk("R1", "region idle", int'(region_o), 0);
        chk("R1", "strobes idle", int'(ref_smp_o) + int'(dat_smp_o), 0);
        repeat (15) @(negedge clk);
        run_frame(5, 3, 4, 6, 2, 1, 1'b0, 1'b1);
        run_frame(0, 0, 0, 8, 3, 2, 1'b1, 1'b0);
        run_frame(2, 2, 1, 7, 1, 3, 1'b0, 1'b1);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 watchdog expired: actual running expected finished");
            finish_run();
        end
    end

endmodule